// File: doc/BRIEF.md
# Single-Precision Float Comparator

This block ranks two 32-bit IEEE-754 single-precision operands. It does not decode exponent and fraction into magnitudes. It takes the raw bit patterns as two's-complement integers and compares them. That integer result is already right for non-negative pairs and for pairs of mixed sign. When both operands are negative, the block reverses the result, because the float value falls as the pattern grows. Two corrections are laid over this. A pair of zeros of either sign counts as equal. Any NaN operand makes the pair unordered.

Each accepted pair gives exactly one of four flags: less-than, equal, greater-than or unordered. The flags and a valid strobe are registered, so a result appears one clock after its operands are presented with `valid_in`. The block takes no back-pressure and can accept a new pair on every cycle. Subnormal operands need no special treatment and are ranked by their patterns like any other finite value.

Top module: `fcmp_top`

## Requirements
- R1: When both operands have bit 31 clear, the flags follow the numeric order (for example 0x3F800000 is less than 0x40000000, and 0x00000001 is greater than 0x00000000).
- R2: A negative operand (bit 31 set) compares less than a positive non-zero operand. An example is 0xBF800000 against 0x3F800000.
- R3: When both operands are negative, a larger pattern reports less-than. For example 0xF1000000 is less than 0xF0000000.
- R4: The subnormal 0x80000010 compares greater than 0xF0000000 and less than 0x00000001. Also, 0xF0000000 compares less than 0x70000000.
- R5: Positive zero (0x00000000) and negative zero (0x80000000) report equal in either operand order.
- R6: An operand is NaN when bits 30:23 are all ones and bits 22:0 are not all zero. If either operand is NaN, unord is set and lt, eq and gt are clear.
- R7: Infinities (bits 30:23 all ones, fraction zero) are not NaN. +inf (0x7F800000) is greater than the largest finite positive value, -inf (0xFF800000) is less than the most negative finite value, and two equal infinities report equal.
- R8: Whenever valid_out is high, exactly one of lt, eq, gt, unord is high.
- R9: valid_out is high in the cycle after a cycle in which valid_in was high, and low otherwise. While valid_in is low, the four flags keep their last values.
- R10: The active-high synchronous reset clears valid_out and all four flags on the next clock edge.
- R11: Two identical non-NaN patterns report equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operands on op_a/op_b are to be compared |
| op_a | input | 32 | First operand, single-precision pattern |
| op_b | input | 32 | Second operand, single-precision pattern |
| valid_out | output | 1 | Flags hold the result of the pair accepted one cycle earlier |
| lt | output | 1 | op_a < op_b |
| eq | output | 1 | op_a == op_b (signed zeros equal) |
| gt | output | 1 | op_a > op_b |
| unord | output | 1 | At least one operand is NaN |

## Verification
On every cycle the assertions check the properties that hold for any pair of operands. These are the one-hot rule on the flags, the one-cycle valid timing, flags that hold while idle, the reset clearing, the NaN override and the equality of zeros of either sign. The ordering itself can only be shown by the scoreboard's chosen pairs. These cover the reversal between two negatives, the mixed-sign boundary, subnormals sitting next to zero, and the infinities at both ends. An independent model of each value's rank predicts the expected result for every pair.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic unord;
    } rel_t;

    typedef struct packed {
        logic valid;
        rel_t rel;
    } stage_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op,
    output logic         is_nan,
    output logic         mag_zero
);
    logic exp_full;
    logic frac_nz;

    always_comb begin
        exp_full = &op[W-2 -: EXP_W];
        frac_nz  = |op[FRAC_W-1:0];
        is_nan   = exp_full && frac_nz;
        mag_zero = ~|op[W-2:0];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         nan_a,
    input  logic         nan_b,
    input  logic         zero_a,
    input  logic         zero_b,
    output rel_t         rel
);
    logic int_less;
    logic same_bits;
    logic both_neg;
    logic equal_val;
    logic less_val;

    always_comb begin
        // raw patterns ranked as two's-complement integers
        int_less  = $signed(op_a) < $signed(op_b);
        same_bits = (op_a == op_b);
        both_neg  = op_a[W-1] && op_b[W-1];
        // zeros of opposite sign are one value
        equal_val = same_bits || (zero_a && zero_b);
        // two negatives: integer order runs backwards
        less_val  = !equal_val && (both_neg ? !int_less : int_less);

        rel = '0;
        if (nan_a || nan_b) begin
            rel.unord = 1'b1;
        end else begin
            rel.eq = equal_val;
            rel.lt = less_val;
            rel.gt = !equal_val && !less_val;
        end
    end
endmodule

// File: rtl/fcmp_top.sv
module fcmp_top
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int N_OP  = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_in,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         valid_out,
    output logic         lt,
    output logic         eq,
    output logic         gt,
    output logic         unord
);
    logic [W-1:0]    ops [N_OP];
    logic [N_OP-1:0] nan_v;
    logic [N_OP-1:0] zero_v;
    rel_t            rel_c;
    stage_t          st_d, st_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < N_OP; i++) begin : g_cls
        fcmp_classify #(
            .EXP_W (EXP_W),
            .FRAC_W(FRAC_W)
        ) u_cls (
            .op      (ops[i]),
            .is_nan  (nan_v[i]),
            .mag_zero(zero_v[i])
        );
    end

    fcmp_order #(.W(W)) u_order (
        .op_a  (op_a),
        .op_b  (op_b),
        .nan_a (nan_v[0]),
        .nan_b (nan_v[1]),
        .zero_a(zero_v[0]),
        .zero_b(zero_v[1]),
        .rel   (rel_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_in;
        if (valid_in) begin
            st_d.rel = rel_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_out = st_q.valid;
    assign lt        = st_q.rel.lt;
    assign eq        = st_q.rel.eq;
    assign gt        = st_q.rel.gt;
    assign unord     = st_q.rel.unord;
endmodule

// File: rtl/fcmp_top_chk.sv
module fcmp_top_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst,
    input logic         valid_in,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         valid_out,
    input logic         lt,
    input logic         eq,
    input logic         gt,
    input logic         unord
);
    logic a_nan, b_nan, both_zero;
    assign a_nan     = (&op_a[W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
    assign b_nan     = (&op_b[W-2 -: EXP_W]) && (|op_b[FRAC_W-1:0]);
    assign both_zero = (op_a[W-2:0] == '0) && (op_b[W-2:0] == '0);

    // R8
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> $countones({lt, eq, gt, unord}) == 1);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);

    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> $stable({lt, eq, gt, unord}));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !valid_out && !lt && !eq && !gt && !unord);

    // R6
    nan_unord_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in && (a_nan || b_nan) |=> unord && !lt && !eq && !gt);

    // R5
    zeros_equal_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in && both_zero |=> eq);
endmodule

bind fcmp_top fcmp_top_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op_a(op_a), .op_b(op_b),
    .valid_out(valid_out), .lt(lt), .eq(eq), .gt(gt), .unord(unord)
);

// File: tb/fcmp_top_test.sv
module fcmp_top_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        valid_out, lt, eq, gt, unord;

    int tests_run = 0;
    int tests_failed = 0;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  flags; // {lt,eq,gt,unord}
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_top uut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .op_a(op_a), .op_b(op_b),
        .valid_out(valid_out), .lt(lt), .eq(eq), .gt(gt), .unord(unord)
    );

    // reference: map sign-magnitude value to a signed rank
    function automatic logic signed [33:0] rank(input logic [31:0] x);
        logic signed [33:0] m;
        m = $signed({3'b000, x[30:0]});
        return x[31] ? -m : m;
    endfunction

    function automatic logic [3:0] expect_of(input logic [31:0] a, input logic [31:0] b);
        logic na, nb;
        na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        if (na || nb) return 4'b0001;
        if (rank(a) < rank(b)) return 4'b1000;
        if (rank(a) > rank(b)) return 4'b0010;
        return 4'b0100;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input string tag);
        item_t it;
        @(negedge clk);
        op_a = a; op_b = b; valid_in = 1'b1;
        it.a = a; it.b = b; it.flags = expect_of(a, b); it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_in = 1'b0;
            op_a = 32'h7FC00000; op_b = 32'h3F800000;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (valid_out && !rst) begin
                if (sb_q.size() == 0) begin
                    check("R9 unexpected valid_out", 4'b1, 4'b0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(it.tag, {lt, eq, gt, unord}, it.flags);
                end
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        logic [3:0] held;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset state", {valid_out, lt, eq, gt}, 4'b0000);
        check("R10 reset unord", {3'b000, unord}, 4'b0000);
        rst = 1'b0;

        drive(32'h3F800000, 32'h40000000, "R1 1.0<2.0");
        drive(32'h40000000, 32'h3F800000, "R1 2.0>1.0");
        drive(32'h00000001, 32'h00000000, "R1 denorm>0");
        drive(32'hBF800000, 32'h3F800000, "R2 -1<1");
        drive(32'h00000001, 32'h80000001, "R2 pos>neg");
        drive(32'hF1000000, 32'hF0000000, "R3 neg pair");
        drive(32'hC0000000, 32'hBF800000, "R3 -2<-1");
        drive(32'hBF800000, 32'hC0000000, "R3 -1>-2");
        drive(32'h80000010, 32'hF0000000, "R4 denorm>huge neg");
        drive(32'h80000010, 32'h00000001, "R4 denorm<pos");
        drive(32'hF0000000, 32'h70000000, "R4 neg<pos huge");
        drive(32'h00000000, 32'h80000000, "R5 +0 -0");
        drive(32'h80000000, 32'h00000000, "R5 -0 +0");
        drive(32'h7FC00000, 32'h00000000, "R6 nan a");
        drive(32'h3F800000, 32'hFF800001, "R6 nan b");
        drive(32'h7FFFFFFF, 32'h7FFFFFFF, "R6 nan both");
        drive(32'h7F800000, 32'h7F7FFFFF, "R7 +inf");
        drive(32'hFF800000, 32'hFF7FFFFF, "R7 -inf");
        drive(32'h7F800000, 32'h7F800000, "R7 inf eq");
        drive(32'hFF800000, 32'h7F800000, "R7 -inf<+inf");
        drive(32'hC0490FDB, 32'hC0490FDB, "R11 same neg");
        drive(32'h00012345, 32'h00012345, "R11 same denorm");
        idle(1);
        @(negedge clk);
        // R9: last result visible; now hold while idle with new operands
        held = {lt, eq, gt, unord};
        idle(3);
        @(negedge clk);
        check("R9 hold flags", {lt, eq, gt, unord}, held);
        check("R9 valid low", {3'b000, valid_out}, 4'b0000);
        check("R9 queue drained", sb_q.size() == 0 ? 4'd0 : 4'd1, 4'd0);

        // R10 reset after activity
        drive(32'h3F800000, 32'h40000000, "R9 pre-reset");
        @(negedge clk);
        valid_in = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset clears", {valid_out, lt, eq, gt}, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        check("R10 stays idle", {valid_out, unord, 2'b00}, 4'b0000);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule